// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block decides, cycle by cycle, whether a serial flash device may change its protection bits and whether a program or erase request may touch the array. It holds the protection part of the status register. That part is one lock bit and a block-protect field, three bits wide by default. The block combines those bits with the level of an external write-protect pin. The pin is brought into the clock domain through a flop synchroniser before any decision uses it.

Two protection layers result. The software layer is the block-protect field, which marks an upper slice of the address space as read-only. The hardware layer is a locked mode. It is entered when the synchronised pin is low while the lock bit is set. In this mode every attempt to rewrite the protection bits is refused, so software cannot leave the mode. Only raising the pin leaves it. A pin tied high never enters the locked mode.

Each request is answered one clock later by a single-cycle grant or reject pulse. The command decoder, the non-volatile storage timing and the program or erase sequencing sit outside this block. They act on a grant and drop a reject.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the lock bit reads 0, the block-protect field reads 000, the locked-mode flag is 0 and no grant or reject output is high.
- R2: A change of the write-protect pin reaches the locked-mode flag through exactly SYNC_STAGES flops (default 2). The flag has not moved after the first rising edge that samples the new level and has moved after the second.
- R3: The locked-mode flag is high exactly when the synchronised pin is low and the lock bit is 1. Setting the lock bit while the pin is already low enters the mode in the cycle after the write.
- R4: While locked mode is active, a status write is answered with a reject pulse and the lock bit and block-protect field keep their values. Raising the pin ends the mode, and the next status write is granted.
- R5: Outside locked mode, a status write is answered with a grant pulse in the next cycle, and from that cycle the lock bit and block-protect field show the written values.
- R6: With the pin held high, the locked-mode flag stays 0 even with the lock bit set, and status writes that clear or set the lock bit are granted.
- R7: The block-protect field n selects the protected region. n=0 protects nothing and n=7 protects the whole array. For n from 1 to 6, the top 2^(n-1)/64 of the array is protected, which is every address whose top 7-n bits are all ones. With 24 address bits, n=1 starts at 0xFC0000 and n=6 starts at 0x800000.
- R8: A program or erase request is answered in the next cycle by exactly one pulse. The pulse is a reject when the address lies in the protected region and a grant otherwise.
- R9: Grant and reject outputs are single-cycle pulses, and none appears in a cycle that follows a cycle without the matching request.
- R10: When a status write and a program or erase request arrive in the same cycle, the address is judged against the block-protect field held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin_raw | input | 1 | Asynchronous write-protect pin level, low protects |
| sr_wr_req | input | 1 | Request to rewrite the protection bits |
| sr_new_lock | input | 1 | Lock bit value to write |
| sr_new_bp | input | BP_W | Block-protect value to write |
| pe_req | input | 1 | Program or erase request |
| pe_addr | input | ADDR_W | Target address of the program or erase request |
| sr_wr_grant | output | 1 | Status write accepted (one-cycle pulse) |
| sr_wr_reject | output | 1 | Status write refused (one-cycle pulse) |
| pe_grant | output | 1 | Program or erase allowed (one-cycle pulse) |
| pe_reject | output | 1 | Program or erase refused (one-cycle pulse) |
| hw_locked | output | 1 | Locked-mode flag |
| lock_bit | output | 1 | Current lock bit |
| bp_field | output | BP_W | Current block-protect field |

## Verification
If a protection bit holds a wrong value, the next program or erase request shows it. A boundary address gets the wrong pulse one cycle after the request, and the bit outputs show the bad value at once. A wrong synchroniser depth or a wrong locked-mode term moves the locked-mode flag one cycle early or late after a pin edge. It can also let a status write through while the flag is high. That shows as a grant where a reject belongs, and as protection bits that change in the following cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;

   // One decision for one request: at most one of the two is set.
   typedef struct packed {
      logic grant;
      logic reject;
   } wp_verdict_t;

   localparam wp_verdict_t WP_IDLE = '{grant: 1'b0, reject: 1'b0};

   // Number of partial-region settings a protect field of width w offers
   // (all codes except "nothing" and "everything").
   function automatic int wp_levels(input int w);
      return (1 << w) - 2;
   endfunction

   function automatic wp_verdict_t wp_decide(input logic allow);
      wp_verdict_t v;
      v.grant  = allow;
      v.reject = !allow;
      return v;
   endfunction

endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
   parameter int   STAGES    = 2,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_LEVEL;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_LEVEL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/wp_region.sv
module wp_region #(
   parameter int ADDR_W = 24,
   parameter int BP_W   = 3
) (
   input  logic [BP_W-1:0]   bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam int LEVELS = wp_pkg::wp_levels(BP_W);
   localparam int CODES  = 1 << BP_W;

   if (BP_W < 2) begin : g_bad_bpw
      $error("wp_region: BP_W must be at least 2");
   end
   if (ADDR_W < LEVELS + 1) begin : g_bad_addr
      $error("wp_region: ADDR_W too small for the protect levels");
   end

   logic [CODES-1:0] code_hit;

   assign code_hit[0]       = 1'b0;
   assign code_hit[CODES-1] = 1'b1;

   // Level g protects the top 2^(g-1)/2^LEVELS of the array: the
   // addresses whose top LEVELS+1-g bits are all ones.
   for (genvar g = 1; g <= LEVELS; g++) begin : g_level
      assign code_hit[g] = &addr[ADDR_W-1 : ADDR_W-1-LEVELS+g];
   end

   assign hit = code_hit[bp];

endmodule

// File: rtl/wp_status.sv
module wp_status #(
   parameter int BP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              wr_req,
   input  logic              new_lock,
   input  logic [BP_W-1:0]   new_bp,
   output logic              lock_q,
   output logic [BP_W-1:0]   bp_q,
   output wp_pkg::wp_verdict_t verdict_q
);

   import wp_pkg::*;

   logic accept;

   assign accept = wr_req && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         bp_q   <= '0;
      end else if (accept) begin
         lock_q <= new_lock;
         bp_q   <= new_bp;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      verdict_q <= WP_IDLE;
      else if (wr_req) verdict_q <= wp_decide(!locked);
      else             verdict_q <= WP_IDLE;
   end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl #(
   parameter int ADDR_W      = 24,
   parameter int BP_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin_raw,
   input  logic              sr_wr_req,
   input  logic              sr_new_lock,
   input  logic [BP_W-1:0]   sr_new_bp,
   input  logic              pe_req,
   input  logic [ADDR_W-1:0] pe_addr,
   output logic              sr_wr_grant,
   output logic              sr_wr_reject,
   output logic              pe_grant,
   output logic              pe_reject,
   output logic              hw_locked,
   output logic              lock_bit,
   output logic [BP_W-1:0]   bp_field
);

   import wp_pkg::*;

   logic          wp_level;
   logic          lock_q;
   logic [BP_W-1:0] bp_q;
   logic          region_hit;
   wp_verdict_t   sr_verdict;
   wp_verdict_t   pe_verdict_q;

   wp_sync #(
      .STAGES   (SYNC_STAGES),
      .RST_LEVEL(1'b1)
   ) pin_sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(wp_pin_raw),
      .d_sync (wp_level)
   );

   // Locked mode: pin low with the lock bit set. Rewrites are refused
   // while it holds, so only the pin can end it.
   assign hw_locked = !wp_level && lock_q;

   wp_status #(
      .BP_W(BP_W)
   ) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (hw_locked),
      .wr_req   (sr_wr_req),
      .new_lock (sr_new_lock),
      .new_bp   (sr_new_bp),
      .lock_q   (lock_q),
      .bp_q     (bp_q),
      .verdict_q(sr_verdict)
   );

   // Judged against the field held before any same-cycle rewrite.
   wp_region #(
      .ADDR_W(ADDR_W),
      .BP_W  (BP_W)
   ) region_i (
      .bp  (bp_q),
      .addr(pe_addr),
      .hit (region_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pe_verdict_q <= WP_IDLE;
      else if (pe_req) pe_verdict_q <= wp_decide(!region_hit);
      else             pe_verdict_q <= WP_IDLE;
   end

   assign sr_wr_grant  = sr_verdict.grant;
   assign sr_wr_reject = sr_verdict.reject;
   assign pe_grant     = pe_verdict_q.grant;
   assign pe_reject    = pe_verdict_q.reject;
   assign lock_bit     = lock_q;
   assign bp_field     = bp_q;

endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
   parameter int ADDR_W      = 24,
   parameter int BP_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_pin_raw,
   input logic              sr_wr_req,
   input logic              sr_new_lock,
   input logic [BP_W-1:0]   sr_new_bp,
   input logic              pe_req,
   input logic [ADDR_W-1:0] pe_addr,
   input logic              sr_wr_grant,
   input logic              sr_wr_reject,
   input logic              pe_grant,
   input logic              pe_reject,
   input logic              hw_locked,
   input logic              lock_bit,
   input logic [BP_W-1:0]   bp_field
);

   localparam int WARM = SYNC_STAGES + 2;

   logic [7:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst < WARM)  since_rst <= since_rst + 8'd1;
   end

   // R2 R3
   pin_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= WARM) |->
         (hw_locked == (!$past(wp_pin_raw, SYNC_STAGES) && lock_bit)));

   // R3
   lock_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_locked |-> lock_bit);

   // R4
   locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req && hw_locked) |=>
         (sr_wr_reject && !sr_wr_grant && $stable(lock_bit) && $stable(bp_field)));

   // R5
   open_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req && !hw_locked) |=>
         (sr_wr_grant && lock_bit == $past(sr_new_lock) && bp_field == $past(sr_new_bp)));

   // R7
   none_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_req && bp_field == '0) |=> pe_grant);

   // R7
   all_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_req && bp_field == '1) |=> pe_reject);

   // R8
   pe_one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_req |=> (pe_grant != pe_reject));

   // R9
   pe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_req |=> (!pe_grant && !pe_reject));

   // R9
   sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_wr_req |=> (!sr_wr_grant && !sr_wr_reject));

   // R9
   bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_wr_req |=> ($stable(lock_bit) && $stable(bp_field)));

endmodule

bind wp_ctrl wp_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .BP_W       (BP_W),
   .SYNC_STAGES(SYNC_STAGES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_pin_raw  (wp_pin_raw),
   .sr_wr_req   (sr_wr_req),
   .sr_new_lock (sr_new_lock),
   .sr_new_bp   (sr_new_bp),
   .pe_req      (pe_req),
   .pe_addr     (pe_addr),
   .sr_wr_grant (sr_wr_grant),
   .sr_wr_reject(sr_wr_reject),
   .pe_grant    (pe_grant),
   .pe_reject   (pe_reject),
   .hw_locked   (hw_locked),
   .lock_bit    (lock_bit),
   .bp_field    (bp_field)
);

// File: tb/wp_ctrl_tb.sv
module wp_ctrl_tb_top;

   localparam int ADDR_W = 24;
   localparam int BP_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_pin_raw = 1'b1;
   logic              sr_wr_req = 1'b0;
   logic              sr_new_lock = 1'b0;
   logic [BP_W-1:0]   sr_new_bp = '0;
   logic              pe_req = 1'b0;
   logic [ADDR_W-1:0] pe_addr = '0;
   logic              sr_wr_grant, sr_wr_reject, pe_grant, pe_reject;
   logic              hw_locked, lock_bit;
   logic [BP_W-1:0]   bp_field;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wp_ctrl #(.ADDR_W(ADDR_W), .BP_W(BP_W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_pin_raw(wp_pin_raw),
      .sr_wr_req(sr_wr_req), .sr_new_lock(sr_new_lock), .sr_new_bp(sr_new_bp),
      .pe_req(pe_req), .pe_addr(pe_addr),
      .sr_wr_grant(sr_wr_grant), .sr_wr_reject(sr_wr_reject),
      .pe_grant(pe_grant), .pe_reject(pe_reject),
      .hw_locked(hw_locked), .lock_bit(lock_bit), .bp_field(bp_field));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected protection computed from the fraction rule of R7.
   function automatic bit exp_protected(input int bp, input int addr);
      if (bp == 0) return 1'b0;
      if (bp == 7) return 1'b1;
      return addr >= ((1 << ADDR_W) - (1 << (ADDR_W - 7 + bp)));
   endfunction

   task automatic sr_write(input bit lk, input int bp, input bit exp_grant, input string req);
      int old_lk, old_bp;
      old_lk = lock_bit;
      old_bp = bp_field;
      @(negedge clk);
      sr_wr_req = 1'b1; sr_new_lock = lk; sr_new_bp = bp[BP_W-1:0];
      @(negedge clk);
      sr_wr_req = 1'b0;
      check(sr_wr_grant == exp_grant && sr_wr_reject == !exp_grant, req,
            {sr_wr_grant, sr_wr_reject}, {exp_grant, !exp_grant});
      if (exp_grant)
         check(lock_bit == lk && bp_field == bp, req, {lock_bit, bp_field}, {lk, bp[2:0]});
      else
         check(lock_bit == old_lk && bp_field == old_bp, req, {lock_bit, bp_field}, {old_lk[0], old_bp[2:0]});
   endtask

   task automatic pe_probe(input int addr, input string req);
      bit prot;
      prot = exp_protected(bp_field, addr);
      @(negedge clk);
      pe_req = 1'b1; pe_addr = addr[ADDR_W-1:0];
      @(negedge clk);
      pe_req = 1'b0;
      check(pe_grant == !prot && pe_reject == prot, req, {pe_grant, pe_reject}, {!prot, prot});
   endtask

   task automatic t_reset;
      check(lock_bit == 0 && bp_field == 0 && !hw_locked, "R1", {hw_locked, lock_bit, bp_field}, 0);
      check(!sr_wr_grant && !sr_wr_reject && !pe_grant && !pe_reject, "R1",
            {sr_wr_grant, sr_wr_reject, pe_grant, pe_reject}, 0);
   endtask

   task automatic t_regions;
      for (int n = 0; n < 8; n++) begin
         int lim;
         sr_write(1'b0, n, 1'b1, "R5");
         lim = (n == 0 || n == 7) ? 'h800000 : (1 << ADDR_W) - (1 << (ADDR_W - 7 + n));
         pe_probe(lim - 1, "R7");
         pe_probe(lim, "R7");
         pe_probe('hFFFFFF, "R8");
         pe_probe(0, "R8");
      end
      check(exp_protected(1, 'hFC0000) && !exp_protected(1, 'hFBFFFF), "R7", 0, 1);
   endtask

   task automatic t_pin_high;
      sr_write(1'b1, 2, 1'b1, "R6");
      repeat (4) @(negedge clk);
      check(!hw_locked, "R6", hw_locked, 0);
      sr_write(1'b0, 2, 1'b1, "R6");
      sr_write(1'b1, 1, 1'b1, "R6");
      check(!hw_locked, "R6", hw_locked, 0);
   endtask

   task automatic t_lock;
      // lock bit is 1, bp is 1 from t_pin_high
      @(negedge clk);
      wp_pin_raw = 1'b0;
      @(negedge clk);
      check(!hw_locked, "R2", hw_locked, 0);
      @(negedge clk);
      check(hw_locked, "R2", hw_locked, 1);
      check(hw_locked, "R3", hw_locked, 1);
      sr_write(1'b0, 0, 1'b0, "R4");
      sr_write(1'b1, 7, 1'b0, "R4");
      pe_probe('hFC0000, "R4");
      pe_probe('hFBFFFF, "R4");
      @(negedge clk);
      wp_pin_raw = 1'b1;
      @(negedge clk);
      check(hw_locked, "R2", hw_locked, 1);
      @(negedge clk);
      check(!hw_locked, "R4", hw_locked, 0);
      sr_write(1'b0, 0, 1'b1, "R4");
   endtask

   task automatic t_lock_while_low;
      @(negedge clk);
      wp_pin_raw = 1'b0;
      repeat (3) @(negedge clk);
      check(!hw_locked, "R3", hw_locked, 0);
      sr_write(1'b1, 3, 1'b1, "R3");
      check(hw_locked, "R3", hw_locked, 1);
      @(negedge clk);
      wp_pin_raw = 1'b1;
      repeat (2) @(negedge clk);
      sr_write(1'b0, 0, 1'b1, "R4");
   endtask

   task automatic t_same_cycle;
      // bp is 0: address 0 is open before the write of 7
      @(negedge clk);
      sr_wr_req = 1'b1; sr_new_lock = 1'b0; sr_new_bp = 3'd7;
      pe_req = 1'b1; pe_addr = '0;
      @(negedge clk);
      sr_wr_req = 1'b0; pe_req = 1'b0;
      check(pe_grant && !pe_reject, "R10", {pe_grant, pe_reject}, 2'b10);
      check(bp_field == 7, "R10", bp_field, 7);
      pe_probe(0, "R10");
   endtask

   task automatic t_idle;
      bit seen;
      seen = 1'b0;
      repeat (6) begin
         @(negedge clk);
         seen |= sr_wr_grant | sr_wr_reject | pe_grant | pe_reject;
      end
      check(!seen, "R9", seen, 0);
      @(negedge clk);
      pe_req = 1'b1; pe_addr = '0;
      @(negedge clk);
      pe_req = 1'b0;
      @(negedge clk);
      check(!pe_grant && !pe_reject, "R9", {pe_grant, pe_reject}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_regions();
      t_pin_high();
      t_lock();
      t_lock_while_low();
      t_same_cycle();
      t_idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule